// File: doc/BRIEF.md
# Virtual Page Number and Hash Generator

This block turns a translation request into the values a hashed page-table walker needs. A request carries an effective address, a segment identifier, a two-bit segment-size code and a page shift (the base-two logarithm of the page size). From these the block forms the virtual page number, with the 12 lowest address bits already dropped. It then computes the 39-bit primary hash that picks a page-table group. The secondary hash is the 39-bit complement of the primary hash.

Requests arrive with a valid strobe and can come on every cycle. Each accepted request produces registered results one cycle later. Between requests the result registers keep their last values. Two conditions raise an error flag next to the result: a page shift below 12, and a segment-size code that is not one of the two defined sizes. Turning the hash into a group address and any access to the table are left to the logic downstream.

Top module: `vphash_gen`

## Requirements
- R1: While the synchronous active-low reset is held, at the next clock edge out_valid, out_vpn, out_hash, out_hash2 and out_err all become zero.
- R2: out_valid equals the in_valid value of the previous cycle, so the latency is one cycle and a new request is accepted on every cycle.
- R3: For segment-size code 0 (256 MB segments, segment shift 28), out_vpn = (segment id << 16) | ((address >> 12) & 0xFFFF), kept to 64 bits.
- R4: For segment-size code 1 (1 TB segments, segment shift 40), out_vpn = (segment id << 28) | ((address >> 12) & 0xFFF_FFFF), kept to 64 bits.
- R5: For code 0, out_hash = low 39 bits of (vpn >> 16) XOR ((vpn & 0xFFFF) >> (page shift − 12)).
- R6: For code 1, with top = vpn >> 28, out_hash = low 39 bits of top XOR (top << 25) XOR ((vpn & 0xFFF_FFFF) >> (page shift − 12)).
- R7: out_hash2 is the bitwise complement of out_hash within 39 bits.
- R8: A page shift below 12 sets out_err and the hash is then formed with a right shift of zero. A page shift of 12 or more with a defined code clears out_err.
- R9: Segment-size codes 2 and 3 are reserved. They set out_err, and the page number and hash are then formed exactly as for code 0.
- R10: On a cycle with in_valid low, out_vpn, out_hash, out_hash2 and out_err keep their previous values, whatever the other inputs do.
- R11: Page shifts up to 63 are accepted. When (page shift − 12) is at least the width of the masked low field, the low field adds nothing to the hash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_ea | input | 64 | Effective address |
| in_segid | input | 52 | Segment identifier |
| in_ssize | input | 2 | Segment-size code: 0 = 256 MB, 1 = 1 TB, 2 and 3 reserved |
| in_pshift | input | 6 | Page shift in bits |
| out_valid | output | 1 | Result valid |
| out_vpn | output | 64 | Virtual page number, shifted down by 12 |
| out_hash | output | 39 | Primary hash |
| out_hash2 | output | 39 | Secondary hash |
| out_err | output | 1 | Small page shift or reserved segment-size code |

## Verification
The bench builds the block with its default parameters: a 64-bit address and page number, a 52-bit segment identifier, a 39-bit hash and a 6-bit page-shift field. With the 52-bit identifier, the 256 MB case can push identifier bits past bit 63 of the page number. The 1 TB case XORs a copy of the upper identifier shifted by 25 places, which crosses the 39-bit hash boundary, so both truncations are checked. The 6-bit page shift reaches every value from 0 to 63. This covers the error range below 12 and shifts so large that the whole low field is shifted out in both segment sizes.

// File: rtl/vphash_pkg.sv
// Package: shared constants and the segment-size code for the
// virtual page number / hash generator. Assumes byte addressing and
// a page number held with the low 12 address bits removed.
package vphash_pkg;

    // Number of address bits dropped from every page number
    localparam int PG_BASE_SHIFT   = 12;
    // Segment shift for the small and the large segment size
    localparam int SEG_SHIFT_SMALL = 28;
    localparam int SEG_SHIFT_LARGE = 40;
    // Left shift applied to the upper identifier in the large-segment hash
    localparam int LARGE_MIX_SHIFT = 25;

    // Segment-size code carried on in_ssize
    typedef enum logic [1:0] {
        SEG_SMALL = 2'd0,
        SEG_LARGE = 2'd1,
        SEG_RSV_A = 2'd2,
        SEG_RSV_B = 2'd3
    } seg_size_e;

endpackage

// File: rtl/vphash_param_check.sv
// Module: decodes the segment-size code and the page shift. It gives
// the large-segment select, the right shift applied to the low page
// field (page shift minus 12, clamped to zero), and the error flag.
// Assumes reserved codes are handled as the small segment size.
module vphash_param_check
    import vphash_pkg::*;
#(
    parameter int PSHIFT_W = 6
) (
    input  logic [1:0]          ssize,
    input  logic [PSHIFT_W-1:0] pshift,
    output logic                large_seg,
    output logic [PSHIFT_W-1:0] shift_amt,
    output logic                err
);

    localparam logic [PSHIFT_W-1:0] BASE = PSHIFT_W'(PG_BASE_SHIFT);

    seg_size_e code;
    logic      shift_low;
    logic      code_bad;

    // Classify the segment-size code
    always_comb begin
        code      = seg_size_e'(ssize);
        large_seg = 1'b0;
        code_bad  = 1'b0;
        case (code)
            SEG_SMALL: large_seg = 1'b0;
            SEG_LARGE: large_seg = 1'b1;
            default:   code_bad  = 1'b1;
        endcase
    end

    // Derive the low-field right shift, clamped to zero for small pages
    always_comb begin
        shift_low = (pshift < BASE);
        shift_amt = shift_low ? '0 : (pshift - BASE);
    end

    // Combine the two error causes
    always_comb begin
        err = shift_low | code_bad;
    end

endmodule

// File: rtl/vphash_vpn_form.sv
// Module: forms the 12-bit-shifted virtual page number for both
// segment sizes in parallel and selects one. The segment identifier
// is placed above the in-segment page bits. Bits above VPN_W are lost.
module vphash_vpn_form
    import vphash_pkg::*;
#(
    parameter int EA_W    = 64,
    parameter int SEGID_W = 52,
    parameter int VPN_W   = 64
) (
    input  logic [EA_W-1:0]    ea,
    input  logic [SEGID_W-1:0] segid,
    input  logic               large_seg,
    output logic [VPN_W-1:0]   vpn
);

    logic [VPN_W-1:0] sid_w;
    logic [VPN_W-1:0] page_w;
    logic [VPN_W-1:0] cand [2];

    // Widen the identifier and drop the in-page address bits
    always_comb begin
        sid_w  = VPN_W'(segid);
        page_w = VPN_W'(ea >> PG_BASE_SHIFT);
    end

    // One candidate page number per segment size
    for (genvar g = 0; g < 2; g++) begin : g_size
        localparam int SEG_SH = (g == 0) ? SEG_SHIFT_SMALL : SEG_SHIFT_LARGE;
        localparam int OFS    = SEG_SH - PG_BASE_SHIFT;
        localparam logic [VPN_W-1:0] IN_SEG_MASK =
            (VPN_W'(1) << OFS) - VPN_W'(1);

        // Join identifier and in-segment page index
        always_comb begin
            cand[g] = (sid_w << OFS) | (page_w & IN_SEG_MASK);
        end
    end

    // Pick the candidate for the requested segment size
    always_comb begin
        vpn = large_seg ? cand[1] : cand[0];
    end

endmodule

// File: rtl/vphash_mix.sv
// Module: computes the primary and secondary page-table hashes from a
// page number. The small-segment variant XORs the identifier part with
// the shifted low field. The large-segment variant also XORs in a copy
// of the identifier part moved up by 25 places. Assumes shift_amt is
// already clamped.
module vphash_mix
    import vphash_pkg::*;
#(
    parameter int VPN_W    = 64,
    parameter int HASH_W   = 39,
    parameter int PSHIFT_W = 6
) (
    input  logic [VPN_W-1:0]    vpn,
    input  logic                large_seg,
    input  logic [PSHIFT_W-1:0] shift_amt,
    output logic [HASH_W-1:0]   hash_pri,
    output logic [HASH_W-1:0]   hash_sec
);

    logic [VPN_W-1:0] full [2];
    logic [VPN_W-1:0] pick;

    // One hash variant per segment size
    for (genvar g = 0; g < 2; g++) begin : g_var
        localparam int SEG_SH = (g == 0) ? SEG_SHIFT_SMALL : SEG_SHIFT_LARGE;
        localparam int LOW_W  = SEG_SH - PG_BASE_SHIFT;
        localparam logic [VPN_W-1:0] LOW_MASK =
            (VPN_W'(1) << LOW_W) - VPN_W'(1);

        logic [VPN_W-1:0] upper;
        logic [VPN_W-1:0] lower;

        // Split the page number into identifier part and low field
        always_comb begin
            upper = vpn >> LOW_W;
            lower = (vpn & LOW_MASK) >> shift_amt;
        end

        if (g == 0) begin : g_small
            // Small segments: identifier part XOR low field
            always_comb begin
                full[g] = upper ^ lower;
            end
        end else begin : g_large
            // Large segments: add a shifted copy of the identifier part
            always_comb begin
                full[g] = upper ^ (upper << LARGE_MIX_SHIFT) ^ lower;
            end
        end
    end

    // Select the variant and trim to the hash width
    always_comb begin
        pick     = large_seg ? full[1] : full[0];
        hash_pri = HASH_W'(pick);
        hash_sec = HASH_W'(~pick);
    end

endmodule

// File: rtl/vphash_gen.sv
// Module: top of the virtual page number and hash generator. Checks
// the request, forms the page number and hashes, and registers all
// results one cycle after in_valid. Result registers hold while
// in_valid is low. Assumes no back-pressure from downstream.
module vphash_gen
    import vphash_pkg::*;
#(
    parameter int EA_W     = 64,
    parameter int SEGID_W  = 52,
    parameter int VPN_W    = 64,
    parameter int HASH_W   = 39,
    parameter int PSHIFT_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [EA_W-1:0]     in_ea,
    input  logic [SEGID_W-1:0]  in_segid,
    input  logic [1:0]          in_ssize,
    input  logic [PSHIFT_W-1:0] in_pshift,
    output logic                out_valid,
    output logic [VPN_W-1:0]    out_vpn,
    output logic [HASH_W-1:0]   out_hash,
    output logic [HASH_W-1:0]   out_hash2,
    output logic                out_err
);

    logic                large_seg;
    logic [PSHIFT_W-1:0] shift_amt;
    logic                req_err;
    logic [VPN_W-1:0]    vpn_c;
    logic [HASH_W-1:0]   hash_c;
    logic [HASH_W-1:0]   hash2_c;

    vphash_param_check #(
        .PSHIFT_W (PSHIFT_W)
    ) u_check (
        .ssize     (in_ssize),
        .pshift    (in_pshift),
        .large_seg (large_seg),
        .shift_amt (shift_amt),
        .err       (req_err)
    );

    vphash_vpn_form #(
        .EA_W    (EA_W),
        .SEGID_W (SEGID_W),
        .VPN_W   (VPN_W)
    ) u_vpn (
        .ea        (in_ea),
        .segid     (in_segid),
        .large_seg (large_seg),
        .vpn       (vpn_c)
    );

    vphash_mix #(
        .VPN_W    (VPN_W),
        .HASH_W   (HASH_W),
        .PSHIFT_W (PSHIFT_W)
    ) u_mix (
        .vpn       (vpn_c),
        .large_seg (large_seg),
        .shift_amt (shift_amt),
        .hash_pri  (hash_c),
        .hash_sec  (hash2_c)
    );

    // Valid strobe follows the request strobe by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // Capture results on accepted requests, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vpn   <= '0;
            out_hash  <= '0;
            out_hash2 <= '0;
            out_err   <= 1'b0;
        end else if (in_valid) begin
            out_vpn   <= vpn_c;
            out_hash  <= hash_c;
            out_hash2 <= hash2_c;
            out_err   <= req_err;
        end
    end

endmodule

// File: rtl/vphash_gen_chk.sv
// Module: property checker for vphash_gen, attached through bind.
// Assumes EA_W of at least 40 so the in-segment address bits exist.
module vphash_gen_chk #(
    parameter int EA_W     = 64,
    parameter int VPN_W    = 64,
    parameter int HASH_W   = 39,
    parameter int PSHIFT_W = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [EA_W-1:0]     in_ea,
    input logic [1:0]          in_ssize,
    input logic [PSHIFT_W-1:0] in_pshift,
    input logic                out_valid,
    input logic [VPN_W-1:0]    out_vpn,
    input logic [HASH_W-1:0]   out_hash,
    input logic [HASH_W-1:0]   out_hash2,
    input logic                out_err
);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r3_low_page: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ssize == 2'd0) |=> (out_vpn[15:0] == $past(in_ea[27:12])));

    a_r4_low_page: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ssize == 2'd1) |=> (out_vpn[27:0] == $past(in_ea[39:12])));

    a_r7_complement: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hash2 == ~out_hash));

    a_r8_small_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_pshift < PSHIFT_W'(12)) |=> out_err);

    a_r8_clean_request: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ssize[1] && in_pshift >= PSHIFT_W'(12)) |=> !out_err);

    a_r9_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ssize[1]) |=> out_err);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_vpn) && $stable(out_hash)
                       && $stable(out_hash2) && $stable(out_err)));

endmodule

bind vphash_gen vphash_gen_chk #(
    .EA_W     (EA_W),
    .VPN_W    (VPN_W),
    .HASH_W   (HASH_W),
    .PSHIFT_W (PSHIFT_W)
) u_vphash_gen_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ea     (in_ea),
    .in_ssize  (in_ssize),
    .in_pshift (in_pshift),
    .out_valid (out_valid),
    .out_vpn   (out_vpn),
    .out_hash  (out_hash),
    .out_hash2 (out_hash2),
    .out_err   (out_err)
);

// File: tb/vphash_gen_bench.sv
// Bench: behavioural reference model updated on each rising edge,
// compared with the design on every falling edge.
module vphash_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_ea = '0;
    logic [51:0] in_segid = '0;
    logic [1:0]  in_ssize = '0;
    logic [5:0]  in_pshift = 6'd12;
    logic        out_valid;
    logic [63:0] out_vpn;
    logic [38:0] out_hash;
    logic [38:0] out_hash2;
    logic        out_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit check_en = 1'b0;
    bit done     = 1'b0;

    vphash_gen u_vphash_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ea     (in_ea),
        .in_segid  (in_segid),
        .in_ssize  (in_ssize),
        .in_pshift (in_pshift),
        .out_valid (out_valid),
        .out_vpn   (out_vpn),
        .out_hash  (out_hash),
        .out_hash2 (out_hash2),
        .out_err   (out_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference page number: identifier scaled by the in-segment span
    function automatic logic [63:0] ref_vpn(logic [63:0] ea, logic [51:0] sid, int ss);
        logic [63:0] span;
        span = (ss == 1) ? (64'd1 << 28) : (64'd1 << 16);
        return ({12'd0, sid} * span) + ((ea / 64'd4096) % span);
    endfunction

    function automatic logic [38:0] ref_hash(logic [63:0] v, int ss, int ps);
        logic [63:0] span, top, low, r;
        int sh;
        sh = (ps < 12) ? 0 : ps - 12;
        span = (ss == 1) ? (64'd1 << 28) : (64'd1 << 16);
        top = v / span;
        low = (v % span) >> sh;
        if (ss == 1) r = top ^ (top * 64'd33554432) ^ low;
        else         r = top ^ low;
        return r[38:0];
    endfunction

    // Model state
    logic        m_valid = 1'b0;
    logic [63:0] m_vpn = '0;
    logic [38:0] m_hash = '0;
    logic [38:0] m_hash2 = '0;
    logic        m_err = 1'b0;
    string       t_vpn = "R3";
    string       t_hash = "R5";
    string       t_err = "R8";

    // Reference model: one register stage, behavioural
    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_vpn   <= '0;
            m_hash  <= '0;
            m_hash2 <= '0;
            m_err   <= 1'b0;
        end else begin
            m_valid <= in_valid;
            if (in_valid) begin
                m_vpn   <= ref_vpn(in_ea, in_segid, int'(in_ssize));
                m_hash  <= ref_hash(ref_vpn(in_ea, in_segid, int'(in_ssize)),
                                    int'(in_ssize), int'(in_pshift));
                m_hash2 <= ~ref_hash(ref_vpn(in_ea, in_segid, int'(in_ssize)),
                                     int'(in_ssize), int'(in_pshift));
                m_err   <= (in_pshift < 6'd12) || (in_ssize >= 2'd2);
                t_vpn   <= (in_ssize >= 2'd2) ? "R9" : (in_ssize == 2'd1) ? "R4" : "R3";
                t_hash  <= (in_ssize >= 2'd2) ? "R9" :
                           (int'(in_pshift) >= ((in_ssize == 2'd1) ? 40 : 28)) ? "R11" :
                           (in_pshift < 6'd12) ? "R8" :
                           (in_ssize == 2'd1) ? "R6" : "R5";
                t_err   <= (in_ssize >= 2'd2) ? "R9" : "R8";
            end
        end
    end

    task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        if (check_en && !done) begin
            string tv, th, te;
            if (!rst_n)        begin tv = "R1"; th = "R1"; te = "R1"; end
            else if (!m_valid) begin tv = "R10"; th = "R10"; te = "R10"; end
            else               begin tv = t_vpn; th = t_hash; te = t_err; end
            chk(rst_n ? "R2" : "R1", "valid", {63'd0, out_valid}, {63'd0, m_valid});
            chk(tv, "vpn", out_vpn, m_vpn);
            chk(th, "hash", {25'd0, out_hash}, {25'd0, m_hash});
            chk((rst_n && m_valid) ? "R7" : th, "hash2", {25'd0, out_hash2}, {25'd0, m_hash2});
            chk(te, "err", {63'd0, out_err}, {63'd0, m_err});
        end
    end

    task automatic send(logic [63:0] ea, logic [51:0] sid, logic [1:0] ss, logic [5:0] ps);
        @(posedge clk);
        #1;
        in_valid  = 1'b1;
        in_ea     = ea;
        in_segid  = sid;
        in_ssize  = ss;
        in_pshift = ps;
    endtask

    // Idle cycle with changing data inputs (R10)
    task automatic idle();
        @(posedge clk);
        #1;
        in_valid  = 1'b0;
        in_ea     = {$urandom, $urandom};
        in_segid  = {$urandom, $urandom};
        in_ssize  = 2'($urandom);
        in_pshift = 6'($urandom);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1: reset with valid held high must still clear outputs
        in_valid = 1'b1;
        in_ea = 64'hFFFF_FFFF_FFFF_FFFF;
        in_segid = '1;
        @(posedge clk);
        #1 check_en = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        in_valid = 1'b0;
        // R3/R5: small segments, several page sizes
        send(64'h0000_0000_0ABC_D123, 52'h1_2345, 2'd0, 6'd12);
        send(64'h0000_0000_0ABC_D123, 52'h1_2345, 2'd0, 6'd16);
        send(64'h0000_0000_0FFF_F000, 52'hF_FFFF_FFFF, 2'd0, 6'd24);
        // R3: identifier bits beyond bit 63 are dropped
        send(64'hDEAD_BEEF_1234_5678, 52'hF_FFFF_FFFF_FFFF, 2'd0, 6'd12);
        idle();
        // R4/R6: large segments, mixing crosses the hash width
        send(64'h0000_00AB_CDEF_0123, 52'h9_8765_4321, 2'd1, 6'd12);
        send(64'h0000_00AB_CDEF_0123, 52'h9_8765_4321, 2'd1, 6'd16);
        send(64'hFFFF_FFFF_FFFF_FFFF, 52'hF_FFFF_FFFF_FFFF, 2'd1, 6'd24);
        send(64'h0000_0012_3456_7000, 52'h0_0000_0001, 2'd1, 6'd34);
        // R11: low field fully shifted out
        send(64'h0000_0000_0FFF_F000, 52'h3_3333, 2'd0, 6'd28);
        send(64'h0000_00FF_FFFF_F000, 52'h3_3333, 2'd1, 6'd40);
        send(64'h0000_00FF_FFFF_F000, 52'h3_3333, 2'd1, 6'd63);
        // R8: page shifts below 12 use a zero shift and flag an error
        send(64'h0000_0000_0ABC_D123, 52'h7_7777, 2'd0, 6'd0);
        send(64'h0000_00AB_CDEF_0123, 52'h7_7777, 2'd1, 6'd11);
        // R9: reserved codes behave as small segments with the flag set
        send(64'h0000_00AB_CDEF_0123, 52'h5_5555_5555, 2'd2, 6'd16);
        send(64'h0000_00AB_CDEF_0123, 52'h5_5555_5555, 2'd3, 6'd12);
        // R10: hold over several idle cycles
        repeat (4) idle();
        // R2: back-to-back pseudo-random burst mixed with gaps
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 5) == 0) idle();
            else send({$urandom, $urandom}, {$urandom, $urandom},
                      2'($urandom), 6'($urandom));
        end
        idle();
        idle();
        // R1: reset in mid-run clears everything
        @(posedge clk);
        #1 rst_n = 1'b0;
        in_valid = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        in_valid = 1'b0;
        idle();
        idle();
        @(negedge clk);
        #1 done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule